// File: doc/BRIEF.md
# Double-Buffered DDS Phase Core

This block is the programming front-end and phase path of a direct digital synthesizer. A 40-bit control word is assembled in a staging register, either one bit per write or one byte per write. The staging register can be filled at any time without disturbing the running output. A rising edge on the update strobe captures the staged word into an update register. On the next clock edge that word becomes the active word, which drives a 32-bit phase accumulator and a 5-bit phase offset. The output is a 14-bit phase value that is ready for a phase-to-amplitude stage.

Several of these cores can share one clock, one reset and one update strobe. After a common reset, each core is loaded with its own offset, for example 0 and 8 steps for quadrature. A common update then starts all of them on the same edge with a known phase relationship. A tuning word of zero holds the phase still. Because reset leaves the staging data in place, a word staged before reset can still be committed afterwards.

All activity is synchronous to `clk`. A write is one clock with `wr_en` high.

Top module: `dds_phase_core`

## Requirements
- R1: While `rst` is high at a clock edge, the active word, the accumulator and the output pipeline clear, so that `phase_out` reads 0 and `mult_en` reads 0 after that edge.
- R2: Reset leaves the staging register unchanged. An update issued after reset, with no new writes, commits the word that was staged before the reset.
- R3: Parallel loading (`ser_mode`=0) takes five bytes in order. Byte 0 is {offset[4:0], ctrl[2:0]}. Bytes 1 to 4 are the tuning word, most significant byte first.
- R4: Serial loading (`ser_mode`=1) takes 40 bits. Bit n goes to word bit n, where the word is {offset[4:0] at 39:35, ctrl[2:0] at 34:32, tuning word at 31:0}. The tuning word is therefore sent LSB first, then ctrl, then the offset.
- R5: Writes beyond the fifth byte or the 40th bit are ignored. The update strobe's rising edge and reset both return the byte and bit counters to the start of the word.
- R6: Only a rising edge of `upd` commits a word. While `upd` stays high, newly staged data does not reach the output.
- R7: A new phase offset first appears on `phase_out` exactly 18 clock edges after the edge that sees `upd` rise. Edge 17 still shows the old value.
- R8: The accumulator adds the active tuning word on every clock, modulo 2^32. `phase_out` equals accumulator bits 31:18 plus offset×512, modulo 2^14. The first step with a new tuning word appears one edge after the new offset.
- R9: With a tuning word of 0, `phase_out` stays constant.
- R10: `mult_en` equals ctrl bit 0 of the active word. It changes on the edge that follows the edge that sees `upd` rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the active path |
| ser_mode | input | 1 | 1 = serial bit loading, 0 = byte loading |
| wr_en | input | 1 | One write per clock while high |
| wr_byte | input | 8 | Byte written in parallel mode |
| wr_bit | input | 1 | Bit written in serial mode |
| upd | input | 1 | Update strobe; its rising edge commits the staged word |
| phase_out | output | 14 | Phase value with the offset applied |
| mult_en | output | 1 | Clock-multiplier enable from the active control bits |

## Verification
The checker watches several behaviours on every cycle. It confirms that the counters stay in range and return to zero after an update edge. It confirms that the update register moves only on a rising strobe and that the active word follows it one edge later. It also checks the accumulator step, the hold at a zero tuning word, the cleared outputs after reset and the timing of `mult_en`. Other behaviours can only be shown by the bench's scenarios. These are the byte and bit ordering of the staged word and the survival of staged data across reset. They also include the exact 18-edge latency, the wrap of the phase, and the absence of any commit while the strobe is held high.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam int unsigned DEF_ACC_W   = 32;
  localparam int unsigned DEF_PH_W    = 14;
  localparam int unsigned DEF_OFF_W   = 5;
  localparam int unsigned DEF_CTRL_W  = 3;
  localparam int unsigned DEF_BYTE_W  = 8;
  localparam int unsigned DEF_LATENCY = 18;

  typedef enum logic {
    LOAD_PAR = 1'b0,
    LOAD_SER = 1'b1
  } load_mode_e;

  function automatic int unsigned word_width(input int unsigned off_w,
                                             input int unsigned ctrl_w,
                                             input int unsigned acc_w);
    return off_w + ctrl_w + acc_w;
  endfunction

endpackage

// File: rtl/dds_stage_loader.sv
module dds_stage_loader
  import dds_pkg::*;
#(
  parameter int unsigned WORD_W = 40,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NBYTES = WORD_W / BYTE_W,
  localparam int unsigned BCNT_W = $clog2(NBYTES + 1),
  localparam int unsigned SCNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  load_mode_e        mode,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              wr_bit,
  input  logic              clr,
  output logic [WORD_W-1:0] stage_word,
  output logic [BCNT_W-1:0] par_cnt,
  output logic [SCNT_W-1:0] ser_cnt
);

  logic [WORD_W-1:0] stage_q;
  logic [WORD_W-1:0] stage_d;
  logic [BCNT_W-1:0] pcnt_q;
  logic [SCNT_W-1:0] scnt_q;
  logic              par_take;
  logic              ser_take;

  assign par_take = wr_en && (mode == LOAD_PAR) && (pcnt_q < BCNT_W'(NBYTES)) && !clr;
  assign ser_take = wr_en && (mode == LOAD_SER) && (scnt_q < SCNT_W'(WORD_W)) && !clr;

  // Next staging value: one byte lane or one bit position per write.
  always_comb begin
    stage_d = stage_q;
    if (par_take) begin
      for (int k = 0; k < NBYTES; k++) begin
        if (pcnt_q == BCNT_W'(k)) begin
          stage_d[WORD_W-1-k*BYTE_W -: BYTE_W] = wr_byte;
        end
      end
    end
    if (ser_take) begin
      for (int n = 0; n < WORD_W; n++) begin
        if (scnt_q == SCNT_W'(n)) begin
          stage_d[n] = wr_bit;
        end
      end
    end
  end

  // Staging data is deliberately outside the reset domain.
  always_ff @(posedge clk) begin
    stage_q <= stage_d;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pcnt_q <= '0;
      scnt_q <= '0;
    end else begin
      if (par_take) pcnt_q <= pcnt_q + 1'b1;
      if (ser_take) scnt_q <= scnt_q + 1'b1;
    end
  end

  assign stage_word = stage_q;
  assign par_cnt    = pcnt_q;
  assign ser_cnt    = scnt_q;

endmodule

// File: rtl/dds_update_sync.sv
module dds_update_sync #(
  parameter int unsigned WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [WORD_W-1:0] stage_word,
  output logic              upd_rise,
  output logic [WORD_W-1:0] hold_word,
  output logic [WORD_W-1:0] active_word
);

  logic              upd_q;
  logic              pend_q;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] active_q;

  assign upd_rise = upd && !upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_q    <= 1'b0;
      pend_q   <= 1'b0;
      hold_q   <= '0;
      active_q <= '0;
    end else begin
      upd_q  <= upd;
      pend_q <= upd_rise;
      if (upd_rise) hold_q   <= stage_word;
      if (pend_q)   active_q <= hold_q;
    end
  end

  assign hold_word   = hold_q;
  assign active_word = active_q;

endmodule

// File: rtl/dds_phase_path.sv
module dds_phase_path #(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned PH_W    = 14,
  parameter int unsigned OFF_W   = 5,
  parameter int unsigned LATENCY = 18,
  localparam int unsigned DEPTH     = LATENCY - 1,
  localparam int unsigned OFF_SHIFT = PH_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] ftw,
  input  logic [OFF_W-1:0] offset,
  output logic [ACC_W-1:0] acc_val,
  output logic [PH_W-1:0]  phase_out
);

  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  phase_c;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_q + ftw;
  end

  assign phase_c = acc_q[ACC_W-1 -: PH_W] + {offset, {OFF_SHIFT{1'b0}}};

  // Delay line that brings the total update-to-output latency to LATENCY.
  generate
    if (DEPTH == 1) begin : g_single
      logic [PH_W-1:0] ph_q;
      always_ff @(posedge clk) begin
        if (rst) ph_q <= '0;
        else     ph_q <= phase_c;
      end
      assign phase_out = ph_q;
    end else begin : g_chain
      logic [DEPTH-1:0][PH_W-1:0] pipe_q;
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[DEPTH-2:0], phase_c};
      end
      assign phase_out = pipe_q[DEPTH-1];
    end
  endgenerate

  assign acc_val = acc_q;

endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
  import dds_pkg::*;
#(
  parameter int unsigned ACC_W   = DEF_ACC_W,
  parameter int unsigned PH_W    = DEF_PH_W,
  parameter int unsigned OFF_W   = DEF_OFF_W,
  parameter int unsigned CTRL_W  = DEF_CTRL_W,
  parameter int unsigned BYTE_W  = DEF_BYTE_W,
  parameter int unsigned LATENCY = DEF_LATENCY,
  localparam int unsigned WORD_W = word_width(OFF_W, CTRL_W, ACC_W),
  localparam int unsigned NBYTES = WORD_W / BYTE_W,
  localparam int unsigned BCNT_W = $clog2(NBYTES + 1),
  localparam int unsigned SCNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_mode,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              wr_bit,
  input  logic              upd,
  output logic [PH_W-1:0]   phase_out,
  output logic              mult_en
);

  logic [WORD_W-1:0] stage_word;
  logic [WORD_W-1:0] hold_word;
  logic [WORD_W-1:0] active_word;
  logic [BCNT_W-1:0] par_cnt;
  logic [SCNT_W-1:0] ser_cnt;
  logic              upd_rise;
  logic [ACC_W-1:0]  acc_val;
  logic [ACC_W-1:0]  ftw;
  logic [OFF_W-1:0]  offset;
  logic [CTRL_W-1:0] ctrl;

  dds_stage_loader #(
    .WORD_W (WORD_W),
    .BYTE_W (BYTE_W)
  ) u_loader (
    .clk        (clk),
    .rst        (rst),
    .mode       (load_mode_e'(ser_mode)),
    .wr_en      (wr_en),
    .wr_byte    (wr_byte),
    .wr_bit     (wr_bit),
    .clr        (upd_rise),
    .stage_word (stage_word),
    .par_cnt    (par_cnt),
    .ser_cnt    (ser_cnt)
  );

  dds_update_sync #(
    .WORD_W (WORD_W)
  ) u_sync (
    .clk         (clk),
    .rst         (rst),
    .upd         (upd),
    .stage_word  (stage_word),
    .upd_rise    (upd_rise),
    .hold_word   (hold_word),
    .active_word (active_word)
  );

  assign offset = active_word[WORD_W-1 -: OFF_W];
  assign ctrl   = active_word[ACC_W +: CTRL_W];
  assign ftw    = active_word[ACC_W-1:0];

  dds_phase_path #(
    .ACC_W   (ACC_W),
    .PH_W    (PH_W),
    .OFF_W   (OFF_W),
    .LATENCY (LATENCY)
  ) u_path (
    .clk       (clk),
    .rst       (rst),
    .ftw       (ftw),
    .offset    (offset),
    .acc_val   (acc_val),
    .phase_out (phase_out)
  );

  assign mult_en = ctrl[0];

endmodule

// File: rtl/dds_phase_core_chk.sv
module dds_phase_core_chk #(
  parameter int unsigned WORD_W = 40,
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned PH_W   = 14,
  parameter int unsigned NBYTES = 5,
  parameter int unsigned BCNT_W = 3,
  parameter int unsigned SCNT_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              upd_rise,
  input logic [WORD_W-1:0] stage_word,
  input logic [WORD_W-1:0] hold_word,
  input logic [WORD_W-1:0] active_word,
  input logic [BCNT_W-1:0] par_cnt,
  input logic [SCNT_W-1:0] ser_cnt,
  input logic [ACC_W-1:0]  acc_val,
  input logic [ACC_W-1:0]  ftw,
  input logic              mult_en,
  input logic [PH_W-1:0]   phase_out
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phase_out == '0 && mult_en == 1'b0 && acc_val == '0));

  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
    (par_cnt <= BCNT_W'(NBYTES)) && (ser_cnt <= SCNT_W'(WORD_W)));

  assert_cnt_restart_R5: assert property (@(posedge clk) disable iff (rst)
    upd_rise |=> (par_cnt == '0 && ser_cnt == '0));

  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    upd_rise |=> hold_word == $past(stage_word));

  assert_no_capture_R6: assert property (@(posedge clk) disable iff (rst)
    !upd_rise |=> $stable(hold_word));

  assert_commit_R6: assert property (@(posedge clk) disable iff (rst)
    upd_rise |=> ##1 (active_word == $past(hold_word)));

  assert_acc_step_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> acc_val == ACC_W'($past(acc_val) + $past(ftw)));

  assert_zero_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (ftw == '0) |=> $stable(acc_val));

  assert_mult_en_timing_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(upd_rise, 2) |-> $stable(mult_en));

endmodule

bind dds_phase_core dds_phase_core_chk #(
  .WORD_W (WORD_W),
  .ACC_W  (ACC_W),
  .PH_W   (PH_W),
  .NBYTES (NBYTES),
  .BCNT_W (BCNT_W),
  .SCNT_W (SCNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .upd_rise    (upd_rise),
  .stage_word  (stage_word),
  .hold_word   (hold_word),
  .active_word (active_word),
  .par_cnt     (par_cnt),
  .ser_cnt     (ser_cnt),
  .acc_val     (acc_val),
  .ftw         (ftw),
  .mult_en     (mult_en),
  .phase_out   (phase_out)
);

// File: tb/test_dds_phase_core.sv
module test_dds_phase_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic        wr_bit = 1'b0;
  logic        upd = 1'b0;
  logic [13:0] phase_out;
  logic        mult_en;

  int unsigned cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  typedef struct {
    int unsigned cyc;
    logic [13:0] val;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dds_phase_core i_dds_phase_core (
    .clk       (clk),
    .rst       (rst),
    .ser_mode  (ser_mode),
    .wr_en     (wr_en),
    .wr_byte   (wr_byte),
    .wr_bit    (wr_bit),
    .upd       (upd),
    .phase_out (phase_out),
    .mult_en   (mult_en)
  );

  // Scoreboard monitor: compares phase_out against queued expectations.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      exp_t it;
      it = sb_q.pop_front();
      checks++;
      if (it.cyc != cyc || phase_out !== it.val) begin
        errors++;
        $display("FAIL %s phase_out at edge %0d: got %h expected %h",
                 it.tag, it.cyc, phase_out, it.val);
      end
    end
  end

  task automatic expect_ph(input int unsigned c, input logic [13:0] v, input string tag);
    exp_t it;
    it.cyc = c; it.val = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s mult_en: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  task automatic do_reset();
    drain();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    ser_mode = 1'b0; wr_en = 1'b1; wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_par(input logic [4:0] off, input logic [2:0] ctl, input logic [31:0] f);
    put_byte({off, ctl});
    for (int i = 3; i >= 0; i--) put_byte(f[i*8 +: 8]);
  endtask

  task automatic load_ser(input logic [39:0] w);
    ser_mode = 1'b1;
    for (int n = 0; n < 40; n++) begin
      wr_en = 1'b1; wr_bit = w[n];
      @(negedge clk);
    end
    wr_en = 1'b0; ser_mode = 1'b0;
  endtask

  // Returns the edge number that sampled the rising strobe.
  task automatic pulse_upd(output int unsigned e0);
    upd = 1'b1;
    @(negedge clk);
    e0 = cyc;
    upd = 1'b0;
  endtask

  initial begin
    int unsigned e0;
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: state right after reset
    expect_ph(cyc, 14'h0, "R1");
    check_bit("R1", mult_en, 1'b0);

    // R9 / R10: zero tuning word holds phase, ctrl bit0 drives mult_en
    load_par(5'd0, 3'b001, 32'h0);
    pulse_upd(e0);
    check_bit("R10", mult_en, 1'b0);
    @(negedge clk);
    check_bit("R10", mult_en, 1'b1);
    expect_ph(e0 + 18, 14'h0, "R9");
    expect_ph(e0 + 40, 14'h0, "R9");

    // R3 / R7 / R8: parallel load, exact latency, stepping
    do_reset();
    load_par(5'd5, 3'b000, 32'h0004_0000);
    pulse_upd(e0);
    expect_ph(e0 + 17, 14'h0000, "R7");
    expect_ph(e0 + 18, 14'h0A00, "R7");
    expect_ph(e0 + 19, 14'h0A01, "R8");
    expect_ph(e0 + 25, 14'h0A07, "R3");

    // R8: wrap below zero
    do_reset();
    load_par(5'd0, 3'b000, 32'hFFFC_0000);
    pulse_upd(e0);
    expect_ph(e0 + 18, 14'h0000, "R8");
    expect_ph(e0 + 19, 14'h3FFF, "R8");
    expect_ph(e0 + 20, 14'h3FFE, "R8");

    // R4: serial bit order
    do_reset();
    load_ser({5'd3, 3'b001, 32'h0008_0000});
    pulse_upd(e0);
    @(negedge clk);
    check_bit("R4", mult_en, 1'b1);
    expect_ph(e0 + 18, 14'h0600, "R4");
    expect_ph(e0 + 19, 14'h0602, "R4");
    expect_ph(e0 + 21, 14'h0606, "R4");

    // R2: staged data survives reset
    do_reset();
    load_par(5'd4, 3'b001, 32'h0);
    do_reset();
    expect_ph(cyc, 14'h0, "R1");
    check_bit("R1", mult_en, 1'b0);
    pulse_upd(e0);
    @(negedge clk);
    check_bit("R2", mult_en, 1'b1);
    expect_ph(e0 + 18, 14'h0800, "R2");

    // R5: a sixth byte is ignored
    do_reset();
    load_par(5'd1, 3'b000, 32'h0);
    put_byte(8'hFF);
    pulse_upd(e0);
    expect_ph(e0 + 18, 14'h0200, "R5");
    expect_ph(e0 + 40, 14'h0200, "R5");

    // R5: reset restarts the byte counter
    do_reset();
    put_byte({5'd9, 3'b000});
    put_byte(8'h55);
    do_reset();
    load_par(5'd6, 3'b000, 32'h0);
    pulse_upd(e0);
    expect_ph(e0 + 18, 14'h0C00, "R5");

    // R5: update restarts the byte counter
    do_reset();
    put_byte({5'd9, 3'b000});
    put_byte(8'h00);
    pulse_upd(e0);
    load_par(5'd7, 3'b000, 32'h0);
    pulse_upd(e0);
    expect_ph(e0 + 18, 14'h0E00, "R5");

    // R6: holding upd high commits nothing further
    do_reset();
    load_par(5'd1, 3'b000, 32'h0);
    upd = 1'b1;
    @(negedge clk);
    e0 = cyc;
    expect_ph(e0 + 18, 14'h0200, "R6");
    load_par(5'd3, 3'b001, 32'h0);
    repeat (30) @(negedge clk);
    expect_ph(cyc + 1, 14'h0200, "R6");
    @(negedge clk);
    check_bit("R6", mult_en, 1'b0);
    upd = 1'b0;
    @(negedge clk);
    pulse_upd(e0);
    expect_ph(e0 + 18, 14'h0600, "R6");
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at edge %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule